// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block is a word-per-line cache built on a direct-mapped array that is split into a lower and an upper half. A read first looks at its home slot, chosen by the ordinary index bits of the address. If the home slot does not hold the block, a second look is made one cycle later at the alternate slot. The alternate slot has the same index with its most significant bit inverted, so it sits in the other half of the array. A match there is answered one cycle later than a home-slot match. The two lines then trade places, so the block that was just used now sits in its home slot.

When neither slot holds the block, the controller sends one read to the lower-level memory and waits for the data. It places the fetched word in the home slot and moves the line that was there into the alternate slot. Whatever the alternate slot held before is dropped. Writes go through to memory and do not allocate. They update the cached copy in whichever slot holds it.

The processor side uses a request handshake (valid and ready) and a response that is a single-cycle valid pulse. While the controller is busy with a second look or a refill, it holds ready low.

Top module: `pac_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0.
- R2: A read whose block is in its home slot (index = address bits [IDX_W-1:0]) gives `rsp_valid_o` in the cycle after acceptance, with `rsp_kind_o` = 2'd0 and the stored word. It issues no memory request.
- R3: A read whose block is in the alternate slot (home index with bit IDX_W-1 inverted) gives `rsp_valid_o` two cycles after acceptance, with `rsp_kind_o` = 2'd1 and the stored word.
- R4: A read that finds its block in neither slot issues exactly one memory read (`mem_req_we_o` = 0) for the request address. One cycle after `mem_rsp_valid_i`, it responds with `rsp_kind_o` = 2'd2 and the memory word.
- R5: After an alternate-slot hit, the two lines are swapped, so the next read of the same address is a home-slot hit (kind 2'd0, one cycle).
- R6: A refill writes the new block into the home slot and moves the previous home line to the alternate slot. The previous alternate line is evicted: a later read of the moved block is kind 2'd1, and a later read of the evicted block is kind 2'd2.
- R7: From the cycle after a read is accepted that misses its home slot, `req_ready_o` stays 0 until the cycle in which the response is given.
- R8: A write responds in the cycle after acceptance. Its kind is 2'd0 if the block is in the home slot, 2'd1 if it is in the alternate slot, and 2'd2 if it is not cached. In that same cycle it issues one memory write with the request address and data. It updates the cached copy if one exists and never allocates a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Controller can accept a request |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_kind_o | output | 2 | 0 home hit, 1 alternate hit, 2 miss |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_req_valid_o | output | 1 | One-cycle memory request pulse |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | ADDR_W | Memory request address |
| mem_req_wdata_o | output | DATA_W | Memory write data |
| mem_rsp_valid_i | input | 1 | Refill data valid |
| mem_rsp_rdata_i | input | DATA_W | Refill data |

## Verification
A request is accepted at a rising edge. A home-slot read or any write has its response pulse visible just after the next edge. An alternate-slot read is one edge later. A refill response appears one edge after the edge that samples `mem_rsp_valid_i`.

The bench drives inputs 1 ns after an edge and counts edges until the pulse appears. It compares that count with 1 or 2 exactly, or with more than 2 for a miss. It also records `req_ready_o` one edge after acceptance.

The bench memory model samples memory requests on the falling edge, counts reads and writes, and keeps the last address and data. Each scenario can therefore confirm that a memory request was issued or that none was.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    KIND_HOME = 2'd0,
    KIND_ALT  = 2'd1,
    KIND_MISS = 2'd2
  } pac_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE2 = 2'd1,
    ST_REFILL = 2'd2
  } pac_state_e;
endpackage

// File: rtl/pac_line_array.sv
module pac_line_array #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd0_idx_i,
  output logic              rd0_valid_o,
  output logic [TAG_W-1:0]  rd0_tag_o,
  output logic [DATA_W-1:0] rd0_data_o,
  input  logic [IDX_W-1:0]  rd1_idx_i,
  output logic              rd1_valid_o,
  output logic [TAG_W-1:0]  rd1_tag_o,
  output logic [DATA_W-1:0] rd1_data_o,
  input  logic              wr0_en_i,
  input  logic [IDX_W-1:0]  wr0_idx_i,
  input  logic              wr0_valid_i,
  input  logic [TAG_W-1:0]  wr0_tag_i,
  input  logic [DATA_W-1:0] wr0_data_i,
  input  logic              wr1_en_i,
  input  logic [IDX_W-1:0]  wr1_idx_i,
  input  logic              wr1_valid_i,
  input  logic [TAG_W-1:0]  wr1_tag_i,
  input  logic [DATA_W-1:0] wr1_data_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel0, sel1;
    assign sel0 = wr0_en_i && (wr0_idx_i == IDX_W'(i));
    assign sel1 = wr1_en_i && (wr1_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   valid_q[i] <= 1'b0;
      else if (sel0) valid_q[i] <= wr0_valid_i;
      else if (sel1) valid_q[i] <= wr1_valid_i;
    end

    always_ff @(posedge clk_i) begin
      if (sel0) begin
        tag_q[i]  <= wr0_tag_i;
        data_q[i] <= wr0_data_i;
      end else if (sel1) begin
        tag_q[i]  <= wr1_tag_i;
        data_q[i] <= wr1_data_i;
      end
    end
  end

  assign rd0_valid_o = valid_q[rd0_idx_i];
  assign rd0_tag_o   = tag_q[rd0_idx_i];
  assign rd0_data_o  = data_q[rd0_idx_i];
  assign rd1_valid_o = valid_q[rd1_idx_i];
  assign rd1_tag_o   = tag_q[rd1_idx_i];
  assign rd1_data_o  = data_q[rd1_idx_i];
endmodule

// File: rtl/pac_tag_match.sv
module pac_tag_match #(
  parameter int TAG_W = 7
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             hit_o
);
  assign hit_o = valid_i && (line_tag_i == req_tag_i);
endmodule

// File: rtl/pac_cache.sv
module pac_cache #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  import pac_pkg::*;

  localparam int IDX_W = $clog2(LINES);
  // stored tag keeps the top index bit so either half can hold any block
  localparam int TAG_W = ADDR_W - IDX_W + 1;
  localparam logic [IDX_W-1:0] IDX_MSB = {1'b1, {(IDX_W-1){1'b0}}};

  pac_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              ld_addr;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic [IDX_W-1:0]  slot_idx   [2];
  logic              slot_valid [2];
  logic [TAG_W-1:0]  slot_tag   [2];
  logic [DATA_W-1:0] slot_data  [2];
  logic              slot_hit   [2];

  logic              wr0_en, wr0_valid, wr1_en, wr1_valid;
  logic [TAG_W-1:0]  wr0_tag, wr1_tag;
  logic [DATA_W-1:0] wr0_data, wr1_data;

  logic              rsp_valid_d, mreq_valid_d, mreq_we_d;
  pac_kind_e         rsp_kind_d;
  logic [DATA_W-1:0] rsp_rdata_d, mreq_wdata_d;
  logic [ADDR_W-1:0] mreq_addr_d;

  assign cur_addr    = (state_q == ST_IDLE) ? req_addr_i : addr_q;
  assign cur_tag     = cur_addr[ADDR_W-1:IDX_W-1];
  assign slot_idx[0] = cur_addr[IDX_W-1:0];
  assign slot_idx[1] = cur_addr[IDX_W-1:0] ^ IDX_MSB;
  assign req_ready_o = (state_q == ST_IDLE);

  pac_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd0_idx_i  (slot_idx[0]),
    .rd0_valid_o(slot_valid[0]),
    .rd0_tag_o  (slot_tag[0]),
    .rd0_data_o (slot_data[0]),
    .rd1_idx_i  (slot_idx[1]),
    .rd1_valid_o(slot_valid[1]),
    .rd1_tag_o  (slot_tag[1]),
    .rd1_data_o (slot_data[1]),
    .wr0_en_i   (wr0_en),
    .wr0_idx_i  (slot_idx[0]),
    .wr0_valid_i(wr0_valid),
    .wr0_tag_i  (wr0_tag),
    .wr0_data_i (wr0_data),
    .wr1_en_i   (wr1_en),
    .wr1_idx_i  (slot_idx[1]),
    .wr1_valid_i(wr1_valid),
    .wr1_tag_i  (wr1_tag),
    .wr1_data_i (wr1_data)
  );

  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_tag_match #(.TAG_W(TAG_W)) u_match (
      .valid_i   (slot_valid[p]),
      .line_tag_i(slot_tag[p]),
      .req_tag_i (cur_tag),
      .hit_o     (slot_hit[p])
    );
  end

  always_comb begin
    state_d      = state_q;
    ld_addr      = 1'b0;
    wr0_en       = 1'b0;
    wr0_valid    = slot_valid[0];
    wr0_tag      = slot_tag[0];
    wr0_data     = slot_data[0];
    wr1_en       = 1'b0;
    wr1_valid    = slot_valid[1];
    wr1_tag      = slot_tag[1];
    wr1_data     = slot_data[1];
    rsp_valid_d  = 1'b0;
    rsp_kind_d   = KIND_HOME;
    rsp_rdata_d  = slot_data[0];
    mreq_valid_d = 1'b0;
    mreq_we_d    = 1'b0;
    mreq_addr_d  = cur_addr;
    mreq_wdata_d = req_wdata_i;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          if (req_we_i) begin
            // write-through, no allocate
            rsp_valid_d  = 1'b1;
            mreq_valid_d = 1'b1;
            mreq_we_d    = 1'b1;
            rsp_kind_d   = slot_hit[0] ? KIND_HOME : (slot_hit[1] ? KIND_ALT : KIND_MISS);
            wr0_en       = slot_hit[0];
            wr0_data     = req_wdata_i;
            wr1_en       = slot_hit[1];
            wr1_data     = req_wdata_i;
          end else if (slot_hit[0]) begin
            rsp_valid_d = 1'b1;
          end else begin
            ld_addr = 1'b1;
            state_d = ST_PROBE2;
          end
        end
      end
      ST_PROBE2: begin
        if (slot_hit[1]) begin
          // swap so the used block lands in its home slot
          wr0_en      = 1'b1;
          wr0_valid   = slot_valid[1];
          wr0_tag     = slot_tag[1];
          wr0_data    = slot_data[1];
          wr1_en      = 1'b1;
          wr1_valid   = slot_valid[0];
          wr1_tag     = slot_tag[0];
          wr1_data    = slot_data[0];
          rsp_valid_d = 1'b1;
          rsp_kind_d  = KIND_ALT;
          rsp_rdata_d = slot_data[1];
          state_d     = ST_IDLE;
        end else begin
          mreq_valid_d = 1'b1;
          state_d      = ST_REFILL;
        end
      end
      ST_REFILL: begin
        if (mem_rsp_valid_i) begin
          wr0_en      = 1'b1;
          wr0_valid   = 1'b1;
          wr0_tag     = cur_tag;
          wr0_data    = mem_rsp_rdata_i;
          wr1_en      = 1'b1;
          wr1_valid   = slot_valid[0];
          wr1_tag     = slot_tag[0];
          wr1_data    = slot_data[0];
          rsp_valid_d = 1'b1;
          rsp_kind_d  = KIND_MISS;
          rsp_rdata_d = mem_rsp_rdata_i;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      addr_q          <= '0;
      rsp_valid_o     <= 1'b0;
      rsp_kind_o      <= 2'd0;
      rsp_rdata_o     <= '0;
      mem_req_valid_o <= 1'b0;
      mem_req_we_o    <= 1'b0;
      mem_req_addr_o  <= '0;
      mem_req_wdata_o <= '0;
    end else begin
      state_q         <= state_d;
      if (ld_addr) addr_q <= req_addr_i;
      rsp_valid_o     <= rsp_valid_d;
      rsp_kind_o      <= rsp_kind_d;
      rsp_rdata_o     <= rsp_rdata_d;
      mem_req_valid_o <= mreq_valid_d;
      mem_req_we_o    <= mreq_we_d;
      mem_req_addr_o  <= mreq_addr_d;
      mem_req_wdata_o <= mreq_wdata_d;
    end
  end
endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [1:0]        rsp_kind_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_we_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [DATA_W-1:0] mem_req_wdata_o
);
  logic acc_rd, acc_wr;
  assign acc_rd = req_valid_i && req_ready_o && !req_we_i;
  assign acc_wr = req_valid_i && req_ready_o && req_we_i;

  // R2: a read never triggers memory traffic in the cycle after acceptance
  p_read_no_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rd |=> !mem_req_valid_o);

  // R3: an alternate-slot read answer comes two cycles after acceptance
  p_alt_two_cycles_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd1 && !$past(req_ready_o)) |-> $past(acc_rd, 2));

  // R4: memory reads are only issued while busy
  p_refill_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_we_o) |-> !req_ready_o);

  // R7: an accepted read is answered next cycle or ready drops
  p_ready_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rd |=> (rsp_valid_o || !req_ready_o));

  // R8: a write answers and writes through in the next cycle
  p_write_through_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |=> (rsp_valid_o && mem_req_valid_o && mem_req_we_o
                && mem_req_addr_o == $past(req_addr_i)
                && mem_req_wdata_o == $past(req_wdata_i)));

  // R2: response kind is one of the three defined codes
  p_kind_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_kind_o != 2'd3);
endmodule

bind pac_cache pac_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_we_i       (req_we_i),
  .req_addr_i     (req_addr_i),
  .req_wdata_i    (req_wdata_i),
  .req_ready_o    (req_ready_o),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_kind_o     (rsp_kind_o),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_we_o   (mem_req_we_o),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_req_wdata_o(mem_req_wdata_o)
);

// File: tb/pac_cache_tb_top.sv
`timescale 1ns/1ps
module pac_cache_tb_top;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int MEM_LAT = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              req_ready_o, rsp_valid_o;
  logic [1:0]        rsp_kind_o;
  logic [DATA_W-1:0] rsp_rdata_o;
  logic              mem_req_valid_o, mem_req_we_o;
  logic [ADDR_W-1:0] mem_req_addr_o;
  logic [DATA_W-1:0] mem_req_wdata_o;
  logic              mem_rsp_valid_i = 1'b0;
  logic [DATA_W-1:0] mem_rsp_rdata_i = '0;

  int checks = 0, failures = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [ADDR_W-1:0] last_rd_addr = '0, last_wr_addr = '0;
  logic [DATA_W-1:0] last_wr_data = '0;
  logic [DATA_W-1:0] mem_arr [1 << ADDR_W];

  always #2.5 clk = ~clk;

  pac_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_kind_o(rsp_kind_o), .rsp_rdata_o(rsp_rdata_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_we_o(mem_req_we_o),
    .mem_req_addr_o(mem_req_addr_o), .mem_req_wdata_o(mem_req_wdata_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_rdata_i(mem_rsp_rdata_i)
  );

  // lower-level memory model, observes requests on the falling edge
  always begin
    @(negedge clk);
    if (mem_req_valid_o) begin
      if (mem_req_we_o) begin
        mem_arr[mem_req_addr_o] = mem_req_wdata_o;
        wr_cnt++;
        last_wr_addr = mem_req_addr_o;
        last_wr_data = mem_req_wdata_o;
      end else begin
        rd_cnt++;
        last_rd_addr = mem_req_addr_o;
        repeat (MEM_LAT) @(posedge clk);
        #1;
        mem_rsp_valid_i = 1'b1;
        mem_rsp_rdata_i = mem_arr[last_rd_addr];
        @(posedge clk);
        #1;
        mem_rsp_valid_i = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // exp_lat 0 means "longer than two cycles" (refill)
  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                         input int exp_lat, input logic [31:0] exp_data, input string req);
    int lat;
    int rd0;
    logic rdy_after;
    rd0 = rd_cnt;
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = a;
    check(req_ready_o == 1'b1, req, "ready before read", 32'(req_ready_o), 1);
    @(posedge clk); #1;
    req_valid_i = 1'b0;
    lat = 1;
    rdy_after = req_ready_o;
    while (!rsp_valid_o && lat < 50) begin
      @(posedge clk); #1; lat++;
    end
    check(rsp_valid_o == 1'b1, req, "response seen", 32'(rsp_valid_o), 1);
    check(rsp_kind_o == kind, req, "kind", 32'(rsp_kind_o), 32'(kind));
    check(rsp_rdata_o == exp_data, req, "data", rsp_rdata_o, exp_data);
    if (exp_lat == 0) begin
      check(lat > 2, req, "refill latency", lat, 3);
      check(rd_cnt == rd0 + 1, "R4", "memory reads", rd_cnt - rd0, 1);
      check(last_rd_addr == a, "R4", "memory read addr", 32'(last_rd_addr), 32'(a));
    end else begin
      check(lat == exp_lat, req, "latency", lat, exp_lat);
      check(rd_cnt == rd0, "R2", "no memory read", rd_cnt - rd0, 0);
    end
    check(rdy_after == (exp_lat == 1), "R7", "ready after accept",
          32'(rdy_after), 32'(exp_lat == 1));
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic [1:0] kind);
    int wr0;
    wr0 = wr_cnt;
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(posedge clk); #1;
    req_valid_i = 1'b0; req_we_i = 1'b0;
    check(rsp_valid_o == 1'b1, "R8", "write response next cycle", 32'(rsp_valid_o), 1);
    check(rsp_kind_o == kind, "R8", "write kind", 32'(rsp_kind_o), 32'(kind));
    @(negedge clk); #0.1;
    check(wr_cnt == wr0 + 1, "R8", "memory writes", wr_cnt - wr0, 1);
    check(last_wr_addr == a, "R8", "write addr", 32'(last_wr_addr), 32'(a));
    check(last_wr_data == d, "R8", "write data", last_wr_data, d);
    @(posedge clk); #1;
  endtask

  localparam logic [ADDR_W-1:0] A = 10'h025, B = 10'h045, C = 10'h065;
  localparam logic [ADDR_W-1:0] D = 10'h100, E = 10'h02D;

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem_arr[i] = 32'h5A00_0000 ^ (i * 32'h0001_0101);
    repeat (3) @(posedge clk);
    #1;
    check(req_ready_o == 1'b1, "R1", "ready in reset", 32'(req_ready_o), 1);
    check(rsp_valid_o == 1'b0, "R1", "no response in reset", 32'(rsp_valid_o), 0);
    check(mem_req_valid_o == 1'b0, "R1", "no mem req in reset", 32'(mem_req_valid_o), 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;

    do_read(A, 2'd2, 0, mem_arr[A], "R4");      // cold miss, proves R1 invalid lines
    do_read(A, 2'd0, 1, mem_arr[A], "R2");
    do_read(B, 2'd2, 0, mem_arr[B], "R4");      // home B, alternate A
    do_read(A, 2'd1, 2, mem_arr[A], "R3");      // swap: home A, alt B
    do_read(A, 2'd0, 1, mem_arr[A], "R5");
    do_read(B, 2'd1, 2, mem_arr[B], "R3");      // home B, alt A
    do_read(C, 2'd2, 0, mem_arr[C], "R6");      // home C, alt B, A evicted
    do_read(B, 2'd1, 2, mem_arr[B], "R6");      // home B, alt C
    do_read(A, 2'd2, 0, mem_arr[A], "R6");      // home A, alt B, C evicted

    do_write(A, 32'hDEAD_BEEF, 2'd0);
    do_read(A, 2'd0, 1, 32'hDEAD_BEEF, "R8");
    do_write(B, 32'h0BAD_F00D, 2'd1);
    do_read(B, 2'd1, 2, 32'h0BAD_F00D, "R8");   // home B, alt(13) A
    do_write(D, 32'h1357_9BDF, 2'd2);
    do_read(D, 2'd2, 0, 32'h1357_9BDF, "R8");   // no allocate: still a miss

    // upper-half home slot: E home 13 holds A, slot 5 holds B
    do_read(E, 2'd2, 0, mem_arr[E], "R6");      // home13 E, slot5 A, B evicted
    do_read(A, 2'd0, 1, 32'hDEAD_BEEF, "R6");
    do_read(B, 2'd2, 0, 32'h0BAD_F00D, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule